// File: doc/BRIEF.md
# Read-Sequence Command Unlock Detector

This block sits beside a memory read/write port and watches for a fixed run of six consecutive read accesses to particular addresses. Five fixed addresses have to arrive in a set order. The sixth address then picks one of two commands: a copy of the working array into nonvolatile storage ("store"), or a copy from nonvolatile storage back into the array ("recall"). When the run completes, the block emits a one-cycle start pulse for the chosen command. It also tells the data path to float its outputs for that final access.

Each access is signalled by a single-cycle strobe, which is one pulse per enable-controlled bus cycle. A separate active-low write level marks write accesses. Only the low 14 address bits take part in the match. Any write, or any read that breaks the order, discards the progress made so far.

Two side inputs change the behaviour. A supply-low input suppresses store commands. A busy input from the transfer engine holds the detector idle while a transfer runs.

Top module: `unlock_seq_detect`

## Requirements
- R1: After a synchronous reset, `store_go`, `recall_go` and `dq_float` are all 0, and the detector is idle.
- R2: The prefix is the reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order. None of these five reads drives any output high.
- R3: After the five-address prefix, a sixth read at 0x0FC0 makes `store_go` and `dq_float` high for exactly the one cycle after that strobe's clock edge.
- R4: After the prefix, a sixth read at 0x0C63 makes `recall_go` and `dq_float` high for exactly the one cycle after that strobe's clock edge.
- R5: Address bit 14 never affects matching; only bits 13:0 are compared.
- R6: A strobe with `we_n` = 0 (a write) at any step returns the detector to idle, whatever the address.
- R7: A read whose address is not the expected next one returns the detector to idle, and no command is issued.
- R8: A read at 0x0E38 that breaks a partial sequence counts as step 1 of a new sequence. This includes a mismatching sixth access.
- R9: While `supply_low` is 1, a completed store sequence gives no `store_go`, but `dq_float` still pulses. Recall is not affected by `supply_low`.
- R10: While `engine_busy` is 1, strobes are ignored and the detector is forced idle. A sequence in progress is lost.
- R11: Clock cycles without a strobe do not change the detector's progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | One-cycle pulse per enable-controlled access |
| we_n | input | 1 | Write level, active low (1 = read) |
| addr | input | 15 | Access address |
| supply_low | input | 1 | Store inhibit (low supply) |
| engine_busy | input | 1 | Transfer engine busy |
| store_go | output | 1 | One-cycle store start pulse |
| recall_go | output | 1 | One-cycle recall start pulse |
| dq_float | output | 1 | One-cycle data-output float indication for the sixth access |

## Verification
On every cycle, the assertions check the following:
- The two start pulses are never high together.
- Each start pulse is accompanied by `dq_float` and lasts a single cycle.
- Every float indication traces back to a read strobe that arrived while the engine was idle.
- A store pulse never follows a strobe taken while `supply_low` was high.

Other behaviours can only be shown by the bench's scenarios, because they depend on the address history:
- the exact address order;
- aborts by a write or a stray read;
- the restart on 0x0E38;
- bit 14 being ignored;
- progress being lost under busy.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int PAT_W    = 14;
  localparam int PRE_LEN  = 5;
  localparam int NPAT     = PRE_LEN + 2;
  localparam int STEP_W   = $clog2(PRE_LEN + 1);
  localparam int IDX_STORE  = PRE_LEN;
  localparam int IDX_RECALL = PRE_LEN + 1;

  function automatic logic [PAT_W-1:0] seq_pat(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      4:       return 14'h303F;
      5:       return 14'h0FC0;
      default: return 14'h0C63;
    endcase
  endfunction
endpackage

// File: rtl/addr_matcher.sv
module addr_matcher
  import unlock_pkg::*;
(
  input  logic [PAT_W-1:0] cmp_addr,
  output logic [NPAT-1:0]  hit
);
  for (genvar i = 0; i < NPAT; i++) begin : g_cmp
    assign hit[i] = (cmp_addr == seq_pat(i));
  end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker
  import unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              is_read,
  input  logic              busy,
  input  logic [NPAT-1:0]   hit,
  output logic              fin_store,
  output logic              fin_recall
);
  logic [STEP_W-1:0] step;
  logic              at_last;
  logic              pre_hit;

  assign at_last = (step == STEP_W'(PRE_LEN));
  assign pre_hit = !at_last && hit[step];

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      step <= '0;
    end else if (take) begin
      if (!is_read)
        step <= '0;
      else if (pre_hit)
        step <= step + STEP_W'(1);
      else if (hit[0] && !(at_last && (hit[IDX_STORE] || hit[IDX_RECALL])))
        step <= STEP_W'(1);
      else
        step <= '0;
    end
  end

  assign fin_store  = take && is_read && at_last && hit[IDX_STORE];
  assign fin_recall = take && is_read && at_last && hit[IDX_RECALL];
endmodule

// File: rtl/cmd_out.sv
module cmd_out (
  input  logic clk,
  input  logic rst,
  input  logic fin_store,
  input  logic fin_recall,
  input  logic inhibit,
  output logic store_go,
  output logic recall_go,
  output logic dq_float
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_go  <= 1'b0;
      recall_go <= 1'b0;
      dq_float  <= 1'b0;
    end else begin
      store_go  <= fin_store && !inhibit;
      recall_go <= fin_recall;
      dq_float  <= fin_store || fin_recall;
    end
  end
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_stb,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              supply_low,
  input  logic              engine_busy,
  output logic              store_go,
  output logic              recall_go,
  output logic              dq_float
);
  logic [NPAT-1:0] hit;
  logic            take;
  logic            fin_store;
  logic            fin_recall;

  assign take = acc_stb && !engine_busy;

  addr_matcher u_match (
    .cmp_addr (addr[PAT_W-1:0]),
    .hit      (hit)
  );

  seq_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .is_read    (we_n),
    .busy       (engine_busy),
    .hit        (hit),
    .fin_store  (fin_store),
    .fin_recall (fin_recall)
  );

  cmd_out u_out (
    .clk        (clk),
    .rst        (rst),
    .fin_store  (fin_store),
    .fin_recall (fin_recall),
    .inhibit    (supply_low),
    .store_go   (store_go),
    .recall_go  (recall_go),
    .dq_float   (dq_float)
  );
endmodule

// File: rtl/unlock_seq_detect_chk.sv
module unlock_seq_detect_chk (
  input logic clk,
  input logic rst,
  input logic acc_stb,
  input logic we_n,
  input logic supply_low,
  input logic engine_busy,
  input logic store_go,
  input logic recall_go,
  input logic dq_float
);
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(store_go && recall_go));

  a_r4_go_floats: assert property (@(posedge clk) disable iff (rst)
    (store_go || recall_go) |-> dq_float);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (store_go || recall_go) |=> !(store_go || recall_go));

  a_r10_float_source: assert property (@(posedge clk) disable iff (rst)
    dq_float |-> $past(acc_stb && we_n && !engine_busy));

  a_r9_inhibit: assert property (@(posedge clk) disable iff (rst)
    store_go |-> $past(!supply_low));
endmodule

bind unlock_seq_detect unlock_seq_detect_chk u_chk (
  .clk(clk), .rst(rst), .acc_stb(acc_stb), .we_n(we_n),
  .supply_low(supply_low), .engine_busy(engine_busy),
  .store_go(store_go), .recall_go(recall_go), .dq_float(dq_float)
);

// File: tb/unlock_seq_detect_test.sv
module unlock_seq_detect_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_stb = 1'b0;
  logic        we_n = 1'b1;
  logic [14:0] addr = '0;
  logic        supply_low = 1'b0;
  logic        engine_busy = 1'b0;
  logic        store_go, recall_go, dq_float;

  int checks = 0;
  int failures = 0;
  logic pend = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic  s;
    logic  r;
    logic  f;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  unlock_seq_detect uut (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .we_n(we_n), .addr(addr),
    .supply_low(supply_low), .engine_busy(engine_busy),
    .store_go(store_go), .recall_go(recall_go), .dq_float(dq_float)
  );

  task automatic cmp(input string tag, input logic es, input logic er, input logic ef);
    checks++;
    if ({store_go, recall_go, dq_float} !== {es, er, ef}) begin
      failures++;
      $display("FAIL %s: got store/recall/float=%b%b%b expected %b%b%b",
               tag, store_go, recall_go, dq_float, es, er, ef);
    end
  endtask

  always @(posedge clk) pend <= acc_stb && !rst;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (pend) begin
        if (q.size() == 0) begin
          failures++;
          $display("FAIL scoreboard: strobe with no expectation, got %b%b%b expected queued item",
                   store_go, recall_go, dq_float);
        end else begin
          exp_t e;
          e = q.pop_front();
          cmp(e.tag, e.s, e.r, e.f);
        end
      end else begin
        cmp("R11 idle cycle quiet", 1'b0, 1'b0, 1'b0);
      end
    end
  end

  task automatic acc(input logic [14:0] a, input logic wn,
                     input logic es, input logic er, input logic ef, input string tag);
    exp_t e;
    @(negedge clk);
    addr = a; we_n = wn; acc_stb = 1'b1;
    e.s = es; e.r = er; e.f = ef; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    acc_stb = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    acc(a, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic prefix(input logic [14:0] hi, input string tag);
    rd(15'h0E38 | hi, tag);
    rd(15'h31C7 | hi, tag);
    rd(15'h03E0 | hi, tag);
    rd(15'h3C1F | hi, tag);
    rd(15'h303F | hi, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 reset outputs low", 1'b0, 1'b0, 1'b0);

    // R2 / R3: store sequence
    prefix(15'h0000, "R2 prefix quiet");
    acc(15'h0FC0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 store start");
    idle(2);

    // R4: recall sequence, with gaps between accesses (R11)
    rd(15'h0E38, "R11 gap"); idle(3);
    rd(15'h31C7, "R11 gap"); idle(2);
    rd(15'h03E0, "R11 gap");
    rd(15'h3C1F, "R11 gap"); idle(4);
    rd(15'h303F, "R11 gap");
    acc(15'h0C63, 1'b1, 1'b0, 1'b1, 1'b1, "R4 recall start");

    // R5: bit 14 ignored
    prefix(15'h4000, "R5 bit14 prefix");
    acc(15'h4FC0, 1'b1, 1'b1, 1'b0, 1'b1, "R5 store with bit14");

    // R6: write at step 3 aborts
    rd(15'h0E38, "R6 pre"); rd(15'h31C7, "R6 pre");
    acc(15'h03E0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 write step");
    rd(15'h3C1F, "R6 after"); rd(15'h303F, "R6 after");
    acc(15'h0FC0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 no store after write");
    // a write to the final address also gives nothing
    prefix(15'h0000, "R6 prefix");
    acc(15'h0FC0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 write as sixth");

    // R7: stray read aborts
    rd(15'h0E38, "R7 pre"); rd(15'h31C7, "R7 pre"); rd(15'h03E0, "R7 pre");
    rd(15'h1234, "R7 stray");
    rd(15'h3C1F, "R7 after"); rd(15'h303F, "R7 after");
    acc(15'h0C63, 1'b1, 1'b0, 1'b0, 1'b0, "R7 no recall after stray");
    prefix(15'h0000, "R7 prefix");
    acc(15'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R7 bad sixth");

    // R8: 0E38 restarts
    rd(15'h0E38, "R8 pre"); rd(15'h31C7, "R8 pre");
    prefix(15'h0000, "R8 restart prefix");
    acc(15'h0FC0, 1'b1, 1'b1, 1'b0, 1'b1, "R8 store after restart");
    prefix(15'h0000, "R8 prefix");
    rd(15'h0E38, "R8 sixth restarts");
    rd(15'h31C7, "R8 cont"); rd(15'h03E0, "R8 cont");
    rd(15'h3C1F, "R8 cont"); rd(15'h303F, "R8 cont");
    acc(15'h0C63, 1'b1, 1'b0, 1'b1, 1'b1, "R8 recall after sixth restart");

    // R9: store inhibit
    supply_low = 1'b1;
    prefix(15'h0000, "R9 prefix");
    acc(15'h0FC0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 store inhibited float kept");
    prefix(15'h0000, "R9 prefix");
    acc(15'h0C63, 1'b1, 1'b0, 1'b1, 1'b1, "R9 recall unaffected");
    supply_low = 1'b0;

    // R10: busy ignores strobes and clears progress
    @(negedge clk); engine_busy = 1'b1;
    prefix(15'h0000, "R10 busy prefix");
    acc(15'h0FC0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 busy no store");
    @(negedge clk); engine_busy = 1'b0;
    rd(15'h0E38, "R10 pre"); rd(15'h31C7, "R10 pre"); rd(15'h03E0, "R10 pre");
    @(negedge clk); engine_busy = 1'b1;
    @(negedge clk); engine_busy = 1'b0;
    rd(15'h3C1F, "R10 after busy"); rd(15'h303F, "R10 after busy");
    acc(15'h0FC0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 progress lost");

    // R1: reset mid-sequence clears progress
    prefix(15'h0000, "R1 prefix");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    acc(15'h0FC0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 reset clears progress");

    idle(3);
    finished = 1'b1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule